// File: doc/BRIEF.md
# Fabric Node Routing Table

This block holds the routing state of a single node in a small coherent processor fabric built from point-to-point links. It has one row for each destination node. Each row carries three separate egress vectors: one for requests, one for responses and one for broadcasts. Each vector can mark the local node and any set of the three outgoing links, so one packet can fan out over several links at once.

Configuration logic writes rows through a word-addressed write port and reads them back through a combinational read port. The packet path asks for a route through a lookup port. It gives a packet class and a destination node ID and receives the egress mask in the same cycle. A separate write places a row in a temporary form in which broadcasts stay local. This is used while a newly found neighbour is being probed. A routing-off bit makes every lookup deliver locally without touching the stored rows. A soft init puts every row back to its default but leaves the routing-off bit alone. Only the hardware reset clears that bit.

Top module: `fabric_route_table`

## Requirements
- R1: After reset every row reads 0x00010101, which routes requests, responses and broadcasts to the local node only.
- R2: A write selects row `wr_addr[4:2]` and ignores `wr_addr[1:0]`. It stores `wr_data[3:0]` as the request vector, `wr_data[11:8]` as the response vector and `wr_data[19:16]` as the broadcast vector. The write shows on `rd_data` and in lookups from the clock cycle after the write edge, and not before it. All other `rd_data` bits read as zero.
- R3: The lookup class encodes 0 as request, 1 as response and 2 as broadcast, and returns the matching vector of row `lk_dest`. Class 3 returns 4'b0000 while routing is on.
- R4: In every egress vector, bit 0 is the local node, bit 1 is link 0, bit 2 is link 1 and bit 3 is link 2. A multi-hot vector comes back from the lookup unchanged.
- R5: A write with `wr_temp` high stores the request and response vectors as given and forces the broadcast vector of that row to 4'b0001.
- R6: While the routing-off bit is set, every lookup returns 4'b0001 for every class and destination. The stored rows are kept, and they route again once the bit is cleared.
- R7: `soft_init` puts every row back to 0x00010101 on the next edge and does not change the routing-off bit.
- R8: Reset clears the routing-off bit.
- R9: The lookup is combinational: a change of `lk_class` or `lk_dest` changes `lk_mask` without a clock edge.
- R10: When `soft_init` and a row write fall on the same edge, `soft_init` wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears rows and the routing-off bit |
| soft_init | input | 1 | Synchronous restore of all rows to default; keeps routing-off |
| wr_en | input | 1 | Row write strobe |
| wr_temp | input | 1 | Temporary write: broadcast vector forced local-only |
| wr_addr | input | 5 | Byte address of the row; bits [4:2] pick the row |
| wr_data | input | 32 | Row word to write |
| rd_addr | input | 5 | Byte address of the row to read |
| rd_data | output | 32 | Row word read back; unused bits zero |
| off_we | input | 1 | Write strobe for the routing-off bit |
| off_d | input | 1 | New value of the routing-off bit |
| lk_class | input | 2 | Packet class: 0 request, 1 response, 2 broadcast |
| lk_dest | input | 3 | Destination node ID |
| lk_mask | output | 4 | Egress mask: bit 0 local, bits 1..3 links 0..2 |

## Verification
The assertions check the following on every cycle: the unused read-back bits stay zero, routing-off forces the local-only mask, class 3 yields an empty mask, and a written word or temporary broadcast override appears on the next cycle. They also check that a soft init restores the defaults while the routing-off bit holds. Only the bench scenarios can show the following: rows keep their contents through a routing-off period, reset clears the routing-off bit, the lookup is combinational within a cycle, and each class reaches its own field across several multi-hot patterns.

// File: rtl/fabric_route_table.sv
module fabric_route_table #(
  parameter int NODES = 8,
  parameter int LINKS = 3,
  localparam int IDX_W = $clog2(NODES),
  localparam int VEC_W = LINKS + 1,
  localparam int ADR_W = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_init,
  input  logic             wr_en,
  input  logic             wr_temp,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [ADR_W-1:0] rd_addr,
  output logic [31:0]      rd_data,
  input  logic             off_we,
  input  logic             off_d,
  input  logic [1:0]       lk_class,
  input  logic [IDX_W-1:0] lk_dest,
  output logic [VEC_W-1:0] lk_mask
);

  localparam logic [VEC_W-1:0] LOCAL_ONLY = VEC_W'(1);
  localparam int RSP_LSB = 8;
  localparam int BC_LSB  = 16;

  logic [VEC_W-1:0] req_q [NODES];
  logic [VEC_W-1:0] rsp_q [NODES];
  logic [VEC_W-1:0] bc_q  [NODES];
  logic             route_off;

  wire [IDX_W-1:0] wr_row = wr_addr[ADR_W-1:2];
  wire [IDX_W-1:0] rd_row = rd_addr[ADR_W-1:2];

  for (genvar g = 0; g < NODES; g++) begin : g_row
    wire hit = wr_en && (wr_row == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[g] <= LOCAL_ONLY;
        rsp_q[g] <= LOCAL_ONLY;
        bc_q[g]  <= LOCAL_ONLY;
      end else if (soft_init) begin
        req_q[g] <= LOCAL_ONLY;
        rsp_q[g] <= LOCAL_ONLY;
        bc_q[g]  <= LOCAL_ONLY;
      end else if (hit) begin
        req_q[g] <= wr_data[VEC_W-1:0];
        rsp_q[g] <= wr_data[RSP_LSB +: VEC_W];
        bc_q[g]  <= wr_temp ? LOCAL_ONLY : wr_data[BC_LSB +: VEC_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      route_off <= 1'b0;
    else if (off_we) route_off <= off_d;
  end

  always_comb begin
    rd_data = '0;
    rd_data[VEC_W-1:0]          = req_q[rd_row];
    rd_data[RSP_LSB +: VEC_W]   = rsp_q[rd_row];
    rd_data[BC_LSB +: VEC_W]    = bc_q[rd_row];
  end

  always_comb begin
    if (route_off) lk_mask = LOCAL_ONLY;
    else begin
      case (lk_class)
        2'd0:    lk_mask = req_q[lk_dest];
        2'd1:    lk_mask = rsp_q[lk_dest];
        2'd2:    lk_mask = bc_q[lk_dest];
        default: lk_mask = '0;
      endcase
    end
  end

endmodule

// File: rtl/fabric_route_table_chk.sv
module fabric_route_table_chk #(
  parameter int NODES = 8,
  parameter int LINKS = 3,
  localparam int IDX_W = $clog2(NODES),
  localparam int VEC_W = LINKS + 1,
  localparam int ADR_W = IDX_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_init,
  input logic             wr_en,
  input logic             wr_temp,
  input logic [ADR_W-1:0] wr_addr,
  input logic [31:0]      wr_data,
  input logic [ADR_W-1:0] rd_addr,
  input logic [31:0]      rd_data,
  input logic             off_we,
  input logic             off_d,
  input logic [1:0]       lk_class,
  input logic [IDX_W-1:0] lk_dest,
  input logic [VEC_W-1:0] lk_mask,
  input logic             route_off
);

  localparam logic [31:0] VMASK = 32'((1 << VEC_W) - 1);
  localparam logic [31:0] USED  = VMASK | (VMASK << 8) | (VMASK << 16);
  localparam logic [31:0] DEFW  = 32'h0001_0101;

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~USED) == 32'h0);

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_temp && !soft_init) |=>
      (rd_addr[ADR_W-1:2] != $past(wr_addr[ADR_W-1:2]) ||
       (rd_data & USED) == ($past(wr_data) & USED)));

  assert_temp_bcast_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_temp && !soft_init) |=>
      (rd_addr[ADR_W-1:2] != $past(wr_addr[ADR_W-1:2]) ||
       rd_data[16 +: VEC_W] == VEC_W'(1)));

  assert_off_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(off_we && off_d) |-> lk_mask == VEC_W'(1));

  assert_class3_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_off && lk_class == 2'd3) |-> lk_mask == '0);

  assert_soft_keeps_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_init && !off_we) |=> $stable(route_off));

  assert_soft_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_init |=> rd_data == DEFW);

endmodule

bind fabric_route_table fabric_route_table_chk #(.NODES(NODES), .LINKS(LINKS)) chk (.*);

// File: tb/fabric_route_table_test.sv
`timescale 1ns/1ps
module fabric_route_table_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_init = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_temp = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        off_we = 1'b0;
  logic        off_d = 1'b0;
  logic [1:0]  lk_class = '0;
  logic [2:0]  lk_dest = '0;
  logic [3:0]  lk_mask;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  fabric_route_table uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_row(input int row, input logic [31:0] d, input bit tmp, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    wr_en = 1'b1; wr_temp = tmp; wr_addr = {3'(row), lo}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_temp = 1'b0;
  endtask

  task automatic set_off(input bit v);
    @(negedge clk);
    off_we = 1'b1; off_d = v;
    @(negedge clk);
    off_we = 1'b0;
  endtask

  function automatic logic [3:0] look(input logic [1:0] c, input int d);
    return 4'b0;
  endfunction

  task automatic lk(string req, input logic [1:0] c, input int d, input logic [3:0] exp);
    lk_class = c; lk_dest = 3'(d);
    #0.5;
    check(req, {28'h0, lk_mask}, {28'h0, exp});
  endtask

  task automatic rd(string req, input int row, input logic [31:0] exp);
    rd_addr = {3'(row), 2'b00};
    #0.5;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 8; r++) rd("R1 reset row", r, 32'h0001_0101);
    lk("R1 reset lookup", 2'd0, 5, 4'b0001);
    lk("R8 reset off clear class3", 2'd3, 5, 4'b0000);
  endtask

  task automatic t_write;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd12; wr_data = 32'hFFFF_FFFF;
    rd_addr = 5'd12;
    #0.5 check("R2 not visible before edge", rd_data, 32'h0001_0101);
    @(negedge clk);
    wr_en = 1'b0;
    rd("R2 unused bits zero", 3, 32'h000F_0F0F);
    wr_row(6, 32'hA50A_0506, 1'b0, 2'b11);
    rd("R2 low addr bits ignored", 6, 32'h000A_0506);
    rd("R2 neighbour row untouched", 7, 32'h0001_0101);
  endtask

  task automatic t_lookup;
    wr_row(2, 32'h000C_0906, 1'b0);
    lk("R3 request field", 2'd0, 2, 4'b0110);
    lk("R3 response field", 2'd1, 2, 4'b1001);
    lk("R4 broadcast multi-hot", 2'd2, 2, 4'b1100);
    lk("R3 class3 empty", 2'd3, 2, 4'b0000);
    lk("R4 all links", 2'd0, 3, 4'b1111);
    lk("R9 combinational dest change", 2'd1, 6, 4'b0101);
  endtask

  task automatic t_temp;
    wr_row(1, 32'h000E_0A0C, 1'b1);
    rd("R5 temp row", 1, 32'h0001_0A0C);
    lk("R5 temp broadcast local", 2'd2, 1, 4'b0001);
    lk("R5 temp request kept", 2'd0, 1, 4'b1100);
  endtask

  task automatic t_off;
    set_off(1'b1);
    for (int c = 0; c < 4; c++) lk("R6 off forces local", 2'(c), 2, 4'b0001);
    lk("R6 off other dest", 2'd0, 3, 4'b0001);
    rd("R6 rows kept while off", 2, 32'h000C_0906);
    set_off(1'b0);
    lk("R6 routes again", 2'd2, 2, 4'b1100);
  endtask

  task automatic t_soft;
    set_off(1'b1);
    @(negedge clk);
    soft_init = 1'b1; wr_en = 1'b1; wr_addr = 5'd16; wr_data = 32'h0002_0202;
    @(negedge clk);
    soft_init = 1'b0; wr_en = 1'b0;
    rd("R10 write dropped under soft init", 4, 32'h0001_0101);
    rd("R7 row restored", 3, 32'h0001_0101);
    lk("R7 off kept through soft init", 2'd3, 4, 4'b0001);
    set_off(1'b0);
    lk("R7 default after soft init", 2'd0, 2, 4'b0001);
  endtask

  task automatic t_rst;
    set_off(1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr_row(5, 32'h0000_0400, 1'b0);
    lk("R8 reset clears off", 2'd1, 5, 4'b0100);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write;
    t_lookup;
    t_temp;
    t_off;
    t_soft;
    t_rst;
    finish_run;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected done");
    finish_run;
  end
endmodule